// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Model

This block models a synchronous static memory whose read and write latencies are equal, so reads and writes can follow each other on every clock with no idle cycle between them. Each word is 36 bits wide, held as four 9-bit lanes. A lane is one data byte plus its parity bit. Address, controls and byte-write enables are captured on the rising clock edge. Read data leaves through a registered output with an output-enable flag, which stands for a tri-state driver. Write data is taken from the input bus two enabled edges after its address was captured.

A sequencer state machine decides the cycle type, and it does so only on a load cycle (`ld_n` low). It has three named states: `ST_DESEL` (nothing selected), `ST_READ` and `ST_WRITE`. It has three transitions:
- LOAD_SEL moves to `ST_READ` or `ST_WRITE` according to `rw_n`, when all three chip enables are active.
- LOAD_DESEL moves to `ST_DESEL`, when any chip enable is inactive.
- ADVANCE (`ld_n` high) keeps the current state and steps a 2-bit wrapping burst counter.

A clock-enable input freezes every register. A snooze input ignores all clock edges and forces the output off, and the array keeps its contents while it is asserted. The default depth is 1K words (`ADDR_W`=10); set `ADDR_W`=16 for 64K words.

Top module: `zbt_sram`

## Requirements
- R1: On an enabled edge with `ld_n`=0 and `ce1_n`=0, `ce2`=1, `ce3_n`=0, the address is captured. The cycle becomes a read when `rw_n`=1 and a write when `rw_n`=0.
- R2: A load cycle with any chip enable inactive deselects the device. The executing slot of that cycle leaves `dq_oe` low, and later advance cycles stay deselected.
- R3: Read data for an address captured at enabled edge k is presented on `dq_o`, with `dq_oe`=1, just after enabled edge k+2. It holds until the next enabled edge.
- R4: For a write whose address was captured at enabled edge k, the data is sampled from `dq_i` at enabled edge k+2. Reads and writes may alternate on every cycle.
- R5: `bw_n` is active low. Bit i gates `dq_i[9i+8:9i]`, a data byte with its parity bit, and these bits are sampled along with each captured address. With `bw_n`=4'b0000 the whole word is written. With 4'b1111 nothing is written.
- R6: On an advance cycle (`ld_n`=1) the previous type continues, and `rw_n` and the chip enables are ignored. The address bits [1:0] increment modulo 4 and the upper bits are kept.
- R7: While `cke_n`=1, clock edges are ignored. No register changes, and `dq_o` and `dq_oe` hold.
- R8: While `zz`=1, `dq_oe` is 0 at once, edges are ignored, and the array contents are kept.
- R9: A read of an address issued right after a write to it, with no gap, returns the newly written lanes merged with the lanes the write left alone.
- R10: While `rst_n` is low, the device is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| zz | input | 1 | Asynchronous snooze, active high |
| cke_n | input | 1 | Clock enable, active low |
| ld_n | input | 1 | 0 = load new address, 1 = burst advance |
| rw_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| bw_n | input | LANES | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_i | input | LANES*LANE_W | Write data bus |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Output driver enable for dq_o |

## Verification
A sequencer left in the wrong state, or a burst counter off by one, shows up at the ports. Either `dq_oe` takes a wrong value or `dq_o` carries the word of a neighbouring address. Both are visible two enabled edges after the faulty capture. A pipeline slot that slips under a clock-enable or snooze freeze shifts every later read by one beat, so the per-cycle comparison reports it on the very next read. A lane gated wrongly by `bw_n` stays hidden until that word is read back. The bench therefore reads each address soon after writing it.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld_n,
    input  logic              rw_n,
    input  logic              ce_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    output op_kind_e          s1_kind,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_bw_n
);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] burst_q, burst_d;
    logic [LANES-1:0]  bw_q;

    // Next-state logic: LOAD_SEL, LOAD_DESEL, ADVANCE
    always_comb begin
        state_d = state_q;
        burst_d = {burst_q[ADDR_W-1:2], burst_q[1:0] + 2'd1};
        if (!ld_n) begin
            burst_d = addr;
            if (!ce_ok)
                state_d = ST_DESEL;
            else if (rw_n)
                state_d = ST_READ;
            else
                state_d = ST_WRITE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            burst_q <= '0;
            bw_q    <= '1;
        end else if (en) begin
            state_q <= state_d;
            burst_q <= burst_d;
            bw_q    <= bw_n;
        end
    end

    // Output decode of the captured operation
    always_comb begin
        unique case (state_q)
            ST_READ:  s1_kind = OP_READ;
            ST_WRITE: s1_kind = OP_WRITE;
            default:  s1_kind = OP_NONE;
        endcase
        s1_addr = burst_q;
        s1_bw_n = bw_q;
    end

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state_q) && $stable(burst_q)));

    // R6
    advance_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ld_n) |=> (state_q == $past(state_q)));

    // R6
    advance_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ld_n) |=> (burst_q[1:0] == $past(burst_q[1:0]) + 2'd1 &&
                          burst_q[ADDR_W-1:2] == $past(burst_q[ADDR_W-1:2])));

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld_n && !ce_ok) |=> (state_q == ST_DESEL));

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_kind_e          s1_kind,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [LANES-1:0]  s1_bw_n,
    output op_kind_e          ex_kind,
    output logic [ADDR_W-1:0] ex_addr,
    output logic [LANES-1:0]  ex_bw_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_kind <= OP_NONE;
            ex_addr <= '0;
            ex_bw_n <= '1;
        end else if (en) begin
            ex_kind <= s1_kind;
            ex_addr <= s1_addr;
            ex_bw_n <= s1_bw_n;
        end
    end

    // R3
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (ex_kind == $past(s1_kind) && ex_addr == $past(s1_addr)));

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         bw_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (en && we && !bw_n[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    zz,
    input  logic                    cke_n,
    input  logic                    ld_n,
    input  logic                    rw_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              ce_ok;
    op_kind_e          s1_kind, ex_kind;
    logic [ADDR_W-1:0] s1_addr, ex_addr;
    logic [LANES-1:0]  s1_bw_n, ex_bw_n;
    logic [DATA_W-1:0] rdata;
    logic              oe_q;
    logic [DATA_W-1:0] dout_q;

    assign en    = !cke_n && !zz;
    assign ce_ok = !ce1_n && ce2 && !ce3_n;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .rw_n(rw_n),
        .ce_ok(ce_ok), .addr(addr), .bw_n(bw_n),
        .s1_kind(s1_kind), .s1_addr(s1_addr), .s1_bw_n(s1_bw_n)
    );

    zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) pipe_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .s1_kind(s1_kind), .s1_addr(s1_addr), .s1_bw_n(s1_bw_n),
        .ex_kind(ex_kind), .ex_addr(ex_addr), .ex_bw_n(ex_bw_n)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .en(en), .we(ex_kind == OP_WRITE),
        .addr(ex_addr), .bw_n(ex_bw_n), .wdata(dq_i), .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            oe_q <= 1'b0;
        else if (en)
            oe_q <= (ex_kind == OP_READ);
    end

    always_ff @(posedge clk) begin
        if (en && ex_kind == OP_READ)
            dout_q <= rdata;
    end

    assign dq_o  = dout_q;
    assign dq_oe = oe_q && !zz;

    // R3
    oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(ex_kind == OP_READ && en));

    // R8
    snooze_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> !dq_oe);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n && !zz) |=> ($stable(oe_q) && $stable(dout_q)));

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
    localparam int AW = 10;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0, zz = 1'b0, cke_n = 1'b0, ld_n = 1'b0, rw_n = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .zz(zz), .cke_n(cke_n), .ld_n(ld_n),
        .rw_n(rw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .bw_n(bw_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct {
        int            kind;
        logic [AW-1:0] a;
        logic [LN-1:0] bw;
    } op_t;

    int checks = 0;
    int errors = 0;

    op_t           pq[$];
    logic [DW-1:0] mm [int];
    int            m_state;
    logic [AW-1:0] m_addr;
    logic          exp_oe = 1'b0;
    logic [DW-1:0] exp_do = '0;

    task automatic model_reset();
        op_t n;
        n.kind = 0; n.a = '0; n.bw = '1;
        pq.delete();
        pq.push_back(n);
        pq.push_back(n);
        m_state = 0;
        m_addr  = '0;
        exp_oe  = 1'b0;
    endtask

    task automatic model_edge();
        op_t ex, n;
        ex = pq.pop_front();
        if (ex.kind == 2) begin
            logic [DW-1:0] w;
            w = mm.exists(int'(ex.a)) ? mm[int'(ex.a)] : 'x;
            for (int i = 0; i < LN; i++)
                if (!ex.bw[i]) w[i*LW +: LW] = dq_i[i*LW +: LW];
            mm[int'(ex.a)] = w;
            exp_oe = 1'b0;
        end else if (ex.kind == 1) begin
            exp_oe = 1'b1;
            exp_do = mm.exists(int'(ex.a)) ? mm[int'(ex.a)] : 'x;
        end else begin
            exp_oe = 1'b0;
        end
        if (!ld_n) begin
            m_addr  = addr;
            m_state = (!ce1_n && ce2 && !ce3_n) ? (rw_n ? 1 : 2) : 0;
        end else begin
            m_addr[1:0] = m_addr[1:0] + 2'd1;
        end
        n.kind = m_state; n.a = m_addr; n.bw = bw_n;
        pq.push_back(n);
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        #1;
        if (!rst_n) model_reset();
        else if (!cke_n && !zz) model_edge();
        check(tag, DW'(dq_oe), DW'(exp_oe && !zz));
        if (exp_oe && !zz) check(tag, dq_o, exp_do);
        dq_i = DW'({$urandom(), $urandom()});
    endtask

    task automatic op(input logic ld, input logic rw, input logic [LN-1:0] bw,
                      input logic [AW-1:0] a, input string tag);
        ld_n = ld; rw_n = rw; bw_n = bw; addr = a;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        step(tag);
    endtask

    task automatic desel(input string tag);
        ld_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; rw_n = 1'b1;
        step(tag);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R10: reset state
        for (int i = 0; i < 4; i++) step("R10");
        rst_n = 1'b1;
        desel("R10");
        desel("R10");

        // R1 R4: back-to-back full writes to 0..15
        for (int i = 0; i < 16; i++) op(1'b0, 1'b0, 4'b0000, AW'(i), "R4");
        desel("R4"); desel("R4");
        // R1 R3: back-to-back reads
        for (int i = 0; i < 16; i++) op(1'b0, 1'b1, 4'b1111, AW'(i), "R3");
        desel("R3"); desel("R3"); desel("R3");

        // R5 R9: partial writes each followed at once by a read
        for (int i = 0; i < 16; i++) begin
            op(1'b0, 1'b0, 4'(i), AW'(i), "R5");
            op(1'b0, 1'b1, 4'b0000, AW'(i), "R9");
        end
        desel("R9"); desel("R9"); desel("R9");

        // R6: write burst from 6 wraps within 4..7, with rw/ce noise on advances
        op(1'b0, 1'b0, 4'b0000, AW'(6), "R6");
        for (int i = 0; i < 5; i++) begin
            ld_n = 1'b1; rw_n = 1'b1; ce1_n = i[0]; ce2 = 1'b0; bw_n = 4'(i);
            step("R6");
        end
        op(1'b0, 1'b1, 4'b1111, AW'(5), "R6");
        for (int i = 0; i < 6; i++) begin
            ld_n = 1'b1; rw_n = 1'b0; ce3_n = 1'b1;
            step("R6");
        end
        desel("R6"); desel("R6"); desel("R6");

        // R2: each chip enable alone deselects; advances stay deselected
        for (int k = 0; k < 3; k++) begin
            op(1'b0, 1'b1, 4'b1111, AW'(1), "R2");
            ld_n = 1'b0; rw_n = 1'b1; ce1_n = (k == 0); ce2 = (k != 1); ce3_n = (k == 2);
            step("R2");
            ld_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
            for (int i = 0; i < 4; i++) step("R2");
        end

        // R7: freeze during a read burst
        op(1'b0, 1'b1, 4'b1111, AW'(8), "R7");
        ld_n = 1'b1; step("R7");
        cke_n = 1'b1; ld_n = 1'b0; rw_n = 1'b0; addr = AW'(3);
        for (int i = 0; i < 3; i++) step("R7");
        cke_n = 1'b0; ld_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R7");

        // R8: snooze in a read stream, with write-like noise on the inputs
        op(1'b0, 1'b1, 4'b1111, AW'(12), "R8");
        ld_n = 1'b1; step("R8");
        zz = 1'b1; ld_n = 1'b0; rw_n = 1'b0; bw_n = 4'b0000; addr = AW'(12);
        for (int i = 0; i < 3; i++) step("R8");
        zz = 1'b0; ld_n = 1'b1; rw_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R8");
        desel("R8"); desel("R8");

        // Random mix over initialised words 0..15
        for (int i = 0; i < 400; i++) begin
            cke_n = ($urandom_range(0, 7) == 0);
            zz    = ($urandom_range(0, 19) == 0);
            ld_n  = ($urandom_range(0, 2) == 0);
            rw_n  = $urandom_range(0, 1) == 1;
            bw_n  = LN'($urandom());
            addr  = AW'($urandom_range(0, 15));
            ce1_n = ($urandom_range(0, 9) == 0);
            ce2   = 1'b1;
            ce3_n = 1'b0;
            step("R9");
        end
        zz = 1'b0; cke_n = 1'b0;
        desel("R1"); desel("R1"); desel("R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule